// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit single-precision floating-point words. Each word has a sign bit, an 8-bit exponent stored with a bias of 127, and a 23-bit fraction with an implied leading one. The block restores the hidden one on both significands, forms the full 48-bit product, and normalizes the product with at most one right shift. It then packs a result word. The low product bits are cut off rather than rounded. Results that leave the representable exponent range saturate: too large gives a signed infinity, too small gives a signed zero. Each saturation raises its own flag.

An operand with a zero exponent field counts as zero. Denormal inputs, NaN handling, rounding modes and traps are not supported. The block has one register stage. Operands presented with `in_valid` high produce `out_valid`, the result and the flags on the next clock edge. The registered outputs hold their values while no new operands arrive.

Top module: `fmul_sp`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `result`, `ovf_flag` and `unf_flag` are all 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The outputs then show the result for the operands sampled with that `in_valid`.
- R3: If either operand has exponent field (bits 30:23) equal to 0, the result has exponent and fraction fields 0 and both flags low.
- R4: Result bit 31 is the XOR of the two operand sign bits (bit 31), in every case including zero and saturated results.
- R5: When the product of the two significands is below 2, the result exponent field is Ea + Eb − 127. The result fraction is product bits 45:23.
- R6: When the product of the two significands is 2 or more, the product shifts right by one and the exponent field becomes Ea + Eb − 126. The result fraction is product bits 46:24.
- R7: Product bits below the kept fraction are discarded without rounding. For example, 0x3FFFFFFF × 0x3FFFFFFF gives 0x407FFFFE.
- R8: If the normalized exponent is 255 or more, the result is exponent field 0xFF with fraction 0, and `ovf_flag` is 1.
- R9: If the normalized exponent is 0 or less, the result has exponent field 0 and fraction 0, and `unf_flag` is 1.
- R10: For in-range results and zero operands, both flags are 0. The two flags are never high together.
- R11: −18 × 9.5 (0xC1900000 × 0x41180000) yields 0xC32B0000: sign 1, exponent 10000110, fraction 0101011 followed by zeros.
- R12: While `in_valid` is low, `result`, `ovf_flag` and `unf_flag` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 32 | First operand, single-precision word |
| op_b | input | 32 | Second operand, single-precision word |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| result | output | 32 | Packed product word |
| ovf_flag | output | 1 | Result saturated to infinity |
| unf_flag | output | 1 | Result saturated to zero by exponent underflow |

## Verification
Operand pairs with exact products, such as 1×1, 2×3 and 1.5×1.5, separate the unshifted path from the path where the product is shifted right by one. Full-fraction operands expose any rounding where truncation is required. The pairs at exponent sums of 254 versus 255 and of 1 versus 0 are each run with and without the normalization shift, so they pin down where saturation starts. Zero operands in each position, mixed signs and a run of random operands complete the set. The random operands are compared against an integer model in the bench that computes the 48-bit product with wide arithmetic.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int BIAS   = 127;

  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int EXPC_W = EXP_W + 2;
  localparam int EMAX   = (1 << EXP_W) - 1;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  bexp;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;

  // Full significand product, hidden ones already present in the inputs.
  function automatic logic [PROD_W-1:0] f_sig_product(
      input logic [SIG_W-1:0] sa, input logic [SIG_W-1:0] sb);
    return {{SIG_W{1'b0}}, sa} * {{SIG_W{1'b0}}, sb};
  endfunction

  // Signed exponent: ea + eb - bias + normalization bump.
  function automatic logic signed [EXPC_W-1:0] f_exp_combine(
      input logic [EXP_W-1:0] ea, input logic [EXP_W-1:0] eb, input logic bump);
    logic signed [EXPC_W-1:0] s;
    s = $signed({2'b00, ea}) + $signed({2'b00, eb})
        - $signed(EXPC_W'(BIAS)) + $signed({{(EXPC_W-1){1'b0}}, bump});
    return s;
  endfunction
endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack
  import fmul_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [EXP_W-1:0]  bexp,
  output logic [SIG_W-1:0]  sig,
  output logic              is_zero
);
  fp_word_t w;
  assign w       = fp_word_t'(word);
  assign sign    = w.sign;
  assign bexp    = w.bexp;
  assign sig     = {1'b1, w.frac};
  assign is_zero = (w.bexp == '0);
endmodule

// File: rtl/fmul_sigmul.sv
module fmul_sigmul
  import fmul_pkg::*;
(
  input  logic [SIG_W-1:0]  sig_a,
  input  logic [SIG_W-1:0]  sig_b,
  output logic [FRAC_W-1:0] frac_n,
  output logic              norm_shift
);
  logic [PROD_W-1:0] prod;

  assign prod       = f_sig_product(sig_a, sig_b);
  assign norm_shift = prod[PROD_W-1];

  // Keep the 23 bits below the leading one; lower bits are truncated.
  always_comb begin
    if (norm_shift) frac_n = prod[PROD_W-2 -: FRAC_W];
    else            frac_n = prod[PROD_W-3 -: FRAC_W];
  end

  // Product of two significands in [1,2) lies in [1,4): one of the top two bits is set
  always_comb begin
    prod_msb_chk: assert (prod[PROD_W-1] | prod[PROD_W-2])
      else $error("significand product lost its leading one");
  end
endmodule

// File: rtl/fmul_pack.sv
module fmul_pack
  import fmul_pkg::*;
(
  input  logic              sign,
  input  logic [EXP_W-1:0]  bexp_a,
  input  logic [EXP_W-1:0]  bexp_b,
  input  logic              any_zero,
  input  logic              norm_shift,
  input  logic [FRAC_W-1:0] frac_n,
  output logic [WORD_W-1:0] word,
  output logic              ovf_evt,
  output logic              unf_evt
);
  logic signed [EXPC_W-1:0] exp_true;
  fp_word_t                 packed_w;

  assign exp_true = f_exp_combine(bexp_a, bexp_b, norm_shift);
  assign ovf_evt  = !any_zero && (exp_true >= $signed(EXPC_W'(EMAX)));
  assign unf_evt  = !any_zero && (exp_true <= $signed(EXPC_W'(0)));

  always_comb begin
    packed_w.sign = sign;
    if (any_zero || unf_evt) begin
      packed_w.bexp = '0;
      packed_w.frac = '0;
    end else if (ovf_evt) begin
      packed_w.bexp = '1;
      packed_w.frac = '0;
    end else begin
      packed_w.bexp = exp_true[EXP_W-1:0];
      packed_w.frac = frac_n;
    end
  end
  assign word = packed_w;

  // R10
  always_comb begin
    ovf_unf_excl_chk: assert (!(ovf_evt && unf_evt))
      else $error("overflow and underflow raised together");
  end
endmodule

// File: rtl/fmul_sp.sv
module fmul_sp
  import fmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              ovf_flag,
  output logic              unf_flag
);
  localparam int NOPS = 2;
  localparam logic [WORD_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic [WORD_W-1:0] ops     [NOPS];
  logic              op_sign [NOPS];
  logic [EXP_W-1:0]  op_exp  [NOPS];
  logic [SIG_W-1:0]  op_sig  [NOPS];
  logic              op_zero [NOPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_unpack
    fmul_unpack u_unpack (
      .word    (ops[g]),
      .sign    (op_sign[g]),
      .bexp    (op_exp[g]),
      .sig     (op_sig[g]),
      .is_zero (op_zero[g])
    );
  end

  logic [FRAC_W-1:0] frac_n;
  logic              norm_shift;

  fmul_sigmul u_sigmul (
    .sig_a      (op_sig[0]),
    .sig_b      (op_sig[1]),
    .frac_n     (frac_n),
    .norm_shift (norm_shift)
  );

  logic [WORD_W-1:0] word_c;
  logic              ovf_evt, unf_evt;

  fmul_pack u_pack (
    .sign       (op_sign[0] ^ op_sign[1]),
    .bexp_a     (op_exp[0]),
    .bexp_b     (op_exp[1]),
    .any_zero   (op_zero[0] | op_zero[1]),
    .norm_shift (norm_shift),
    .frac_n     (frac_n),
    .word       (word_c),
    .ovf_evt    (ovf_evt),
    .unf_evt    (unf_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf_flag  <= 1'b0;
      unf_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= word_c;
        ovf_flag <= ovf_evt;
        unf_flag <= unf_evt;
      end
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R4
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> result[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1]));

  // R3
  zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_a[WORD_W-2:FRAC_W] == '0 || op_b[WORD_W-2:FRAC_W] == '0))
    |=> (result[WORD_W-2:0] == '0) && !ovf_flag && !unf_flag);

  // R8
  ovf_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> result[WORD_W-2:0] == INF_MAG);

  // R9
  unf_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |-> result[WORD_W-2:0] == '0);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(ovf_flag) && $stable(unf_flag));
endmodule

// File: tb/fmul_sp_tb.sv
module fmul_sp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf_flag, unf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fmul_sp u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  typedef struct {
    logic [33:0] exp;  // {word, ovf, unf}
    string       tag;
  } item_t;
  item_t sb_q[$];

  // Independent model with wide integer arithmetic.
  function automatic logic [33:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic s;
    int ea, eb, e;
    longint unsigned p;
    logic [22:0] f;
    s  = a[31] ^ b[31];
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if (ea == 0 || eb == 0) return {s, 31'd0, 2'b00};
    p = 64'({1'b1, a[22:0]}) * 64'({1'b1, b[22:0]});
    e = ea + eb - 127;
    if (p >= (64'd1 << 47)) begin
      e = e + 1;
      p = p >> 1;
    end
    f = 23'(p >> 23);
    if (e > 254) return {s, 8'hFF, 23'd0, 2'b10};
    if (e < 1)   return {s, 31'd0, 2'b01};
    return {s, 8'(e), f, 2'b00};
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h/%b%b expected=%h/%b%b", tag,
               act[33:2], act[1], act[0], exp[33:2], exp[1], exp[0]);
    end
  endtask

  task automatic send_exp(input logic [31:0] a, input logic [31:0] b,
                          input logic [33:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input string tag);
    send_exp(a, b, ref_mul(a, b), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = $urandom;
      op_b = $urandom;
    end
  endtask

  // Monitor: pops the scoreboard whenever the design reports a result.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        check("R2 unexpected out_valid", 34'd1, 34'd0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, {result, ovf_flag, unf_flag}, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [33:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {out_valid, result, ovf_flag, unf_flag}, 35'd0 >> 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    check("R1 after reset idle", {out_valid, result, ovf_flag, unf_flag}, 35'd0 >> 1);

    // R11 reference example
    send_exp(32'hC1900000, 32'h41180000, {32'hC32B0000, 2'b00}, "R11 -18x9.5");
    // R5 no normalization shift
    send_exp(32'h3F800000, 32'h3F800000, {32'h3F800000, 2'b00}, "R5 1x1");
    send_exp(32'h40000000, 32'h40400000, {32'h40C00000, 2'b00}, "R5 2x3");
    // R4 sign combinations
    send_exp(32'h40000000, 32'hC0400000, {32'hC0C00000, 2'b00}, "R4 2x-3");
    send_exp(32'hC0000000, 32'hC0400000, {32'h40C00000, 2'b00}, "R4 -2x-3");
    // R6 normalization shift
    send_exp(32'h3FC00000, 32'h3FC00000, {32'h40100000, 2'b00}, "R6 1.5x1.5");
    send_exp(32'h40400000, 32'h40400000, {32'h41100000, 2'b00}, "R6 3x3");
    // R7 truncation
    send_exp(32'h3FFFFFFF, 32'h3FFFFFFF, {32'h407FFFFE, 2'b00}, "R7 truncate full fractions");
    send(32'h3EAAAAAB, 32'h3EAAAAAB, "R7 one third squared");
    // R3 zero operands
    send_exp(32'h00000000, 32'h40400000, {32'h00000000, 2'b00}, "R3 zero x 3");
    send_exp(32'hC0400000, 32'h00000000, {32'h80000000, 2'b00}, "R3 -3 x zero sign");
    send_exp(32'h007FFFFF, 32'h7F000000, {32'h00000000, 2'b00}, "R3 zero exponent field");
    // R8 overflow boundary
    send_exp(32'h5F800000, 32'h5F000000, {32'h7F000000, 2'b00}, "R10 exponent 254 in range");
    send_exp(32'h5FC00000, 32'h5F400000, {32'h7F800000, 2'b10}, "R8 exponent 255 by shift");
    send_exp(32'hDFC00000, 32'h5F400000, {32'hFF800000, 2'b10}, "R8 negative infinity");
    // R9 underflow boundary
    send_exp(32'h1FC00000, 32'h20400000, {32'h00900000, 2'b00}, "R10 exponent 1 in range");
    send_exp(32'h1F800000, 32'h20000000, {32'h00000000, 2'b01}, "R9 exponent 0");
    send_exp(32'h9F800000, 32'h10000000, {32'h80000000, 2'b01}, "R9 negative underflow");
    // Random operands
    for (int i = 0; i < 40; i++) send($urandom, $urandom, "R5 random pair");
    send_exp(32'h40A00000, 32'h40000000, {32'h41200000, 2'b00}, "R2 last item 5x2");
    // R12 hold while idle
    idle(1);
    held = {result, ovf_flag, unf_flag};
    idle(5);
    check("R12 outputs held", {result, ovf_flag, unf_flag}, {32'h41200000, 2'b00});
    check("R12 no change while idle", {result, ovf_flag, unf_flag}, held);
    check("R2 out_valid low and queue drained",
          34'({out_valid, sb_q.size() != 0}), 34'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule